// File: doc/BRIEF.md
# RTC Status and Write-Protect Register

This block holds the 8-bit volatile status word of a real-time clock. The word sits at a fixed address on an internal byte-wide register bus. It does three jobs. First, it guards the clock/control register window behind two write-enable latches that must be set in a fixed order. Second, it keeps sticky flags for the two alarm comparators and for a total loss of power. Third, it shows the live battery-mode and oscillator-fault inputs.

The register bus is driven by a serial front end outside this block. That front end loads an address with `addr_ld`, then issues byte strobes: `wr_stb` with `wr_data` for a write, `rd_stb` for a read. It closes each byte with `byte_done` and ends the transfer with `stop`. Every strobe lasts one cycle. The block accepts a strobe on any cycle and never applies back-pressure, so the bus has no ready signal.

Every byte write is acknowledged on `wr_ack` one cycle after its strobe. A clock/control write goes out on `ccr_wr_en`, `ccr_wr_addr` and `ccr_wr_data`, with the same one-cycle delay, and only when both latches are set. Status-word writes are staged and take effect at `stop`, with no busy period afterwards.

Top module: `rtc_status_guard`

## Requirements
- R1: After reset, a read of the status address (0x3F) returns 0x01 when `on_batt` and `osc_bad` are low, and `ccr_wr_permit` is low.
- R2: The status word is laid out as BATT bit 7, ALM1 bit 6, ALM0 bit 5, OSC bit 4, bit 3 always 0, KEY bit 2, ARM bit 1, LOSS bit 0. BATT and OSC show the `on_batt` and `osc_bad` inputs sampled in the read strobe cycle. `rd_data` is loaded one cycle after `rd_stb` and holds until the next read.
- R3: A status write of exactly 0x02 sets ARM and clears KEY. A status write of 0x00 clears both ARM and KEY. Any other byte leaves ARM unchanged. A status write takes effect only at `stop`, and the last byte written before `stop` is the one that counts.
- R4: A status write of 0x06 sets KEY only while ARM is already set; with ARM low it changes nothing. `ccr_wr_permit` is high exactly when ARM and KEY are both set.
- R5: Every `wr_stb` produces a one-cycle `wr_ack` on the next cycle, whether or not the write is blocked. A write to the clock/control window (0x10 to 0x37) raises `ccr_wr_en` on the next cycle only when `ccr_wr_permit` is high. That pulse carries the write's address and data on `ccr_wr_addr` and `ccr_wr_data`.
- R6: A one-cycle pulse on `alarm_hit[i]` sets the matching ALM flag, and the flag stays set until it is cleared by a status read.
- R7: At the `byte_done` that ends a status read, only the ALM flags that were set at that read's `rd_stb` are cleared. A flag set during the read stays set.
- R8: LOSS is set by reset and by `pwr_lost`. It is cleared by the first permitted write to the clock section (0x30 to 0x37). A blocked write, or a write elsewhere in the window, leaves it set.
- R9: `ptr_addr` loads on `addr_ld` and otherwise advances by one, wrapping, at each `byte_done`. A read with no address load therefore continues at the next register. A read of any address other than 0x3F returns 0x00.
- R10: `pwr_lost` returns ARM, KEY, both ALM flags and any staged write to their reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_lost | input | 1 | Synchronous total-power-loss restart |
| addr_ld | input | 1 | Load register pointer from addr_in |
| addr_in | input | 6 | Register address |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| rd_stb | input | 1 | Byte read strobe |
| byte_done | input | 1 | Current byte finished (last data bit fell) |
| stop | input | 1 | Bus transfer ended |
| on_batt | input | 1 | Running from backup supply |
| osc_bad | input | 1 | Oscillator fault status |
| alarm_hit | input | 2 | Alarm match pulses, bit i for alarm i |
| rd_data | output | 8 | Read data of the last read strobe |
| ptr_addr | output | 6 | Current register pointer |
| wr_ack | output | 1 | Write byte acknowledged |
| ccr_wr_en | output | 1 | Permitted clock/control write |
| ccr_wr_addr | output | 6 | Address of permitted write |
| ccr_wr_data | output | 8 | Data of permitted write |
| ccr_wr_permit | output | 1 | Clock/control writes unlocked |

## Verification
The assertions assume that every strobe lasts a single cycle and that `wr_stb`, `rd_stb`, `byte_done`, `stop` and `addr_ld` never arrive together. They also assume that `pwr_lost` is a synchronous pulse. The bench meets these assumptions by driving each strobe from its own task, which raises the strobe on one falling edge and drops it on the next. Alarm pulses are the one deliberate exception: they are placed between the read strobe and `byte_done` of a status read, so that the read-window clearing rule is exercised.

// File: rtl/rtc_sr_pkg.sv
package rtc_sr_pkg;
  localparam int ADDR_W   = 6;
  localparam int BIT_BATT = 7;
  localparam int BIT_ALM1 = 6;
  localparam int BIT_ALM0 = 5;
  localparam int BIT_OSC  = 4;
  localparam int BIT_RSV  = 3;
  localparam int BIT_KEY  = 2;
  localparam int BIT_ARM  = 1;
  localparam int BIT_LOSS = 0;

  localparam logic [7:0] CODE_ARM  = 8'h02;
  localparam logic [7:0] CODE_KEY  = 8'h06;
  localparam logic [7:0] CODE_LOCK = 8'h00;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_ARM,
    ACT_KEY,
    ACT_LOCK
  } unlock_act_e;
endpackage

// File: rtl/rtc_sr_addr_ptr.sv
module rtc_sr_addr_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= load_val;
    else if (advance) ptr <= ptr + ONE;
  end
endmodule

// File: rtl/rtc_sr_unlock.sv
module rtc_sr_unlock
  import rtc_sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wipe,
  input  logic       sr_wr,
  input  logic [7:0] wr_byte,
  input  logic       stop,
  output logic       arm,
  output logic       key
);
  logic        pend_v;
  logic [7:0]  pend_d;
  unlock_act_e act;

  always_comb begin
    act = ACT_NONE;
    if (stop && pend_v) begin
      unique case (pend_d)
        CODE_ARM:  act = ACT_ARM;
        CODE_KEY:  act = arm ? ACT_KEY : ACT_NONE;
        CODE_LOCK: act = ACT_LOCK;
        default:   act = ACT_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (wipe || stop) begin
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (sr_wr) begin
      pend_v <= 1'b1;
      pend_d <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm <= 1'b0;
      key <= 1'b0;
    end else if (wipe) begin
      arm <= 1'b0;
      key <= 1'b0;
    end else begin
      unique case (act)
        ACT_ARM:  begin arm <= 1'b1; key <= 1'b0; end
        ACT_KEY:  key <= 1'b1;
        ACT_LOCK: begin arm <= 1'b0; key <= 1'b0; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_sr_alarm_flags.sv
module rtc_sr_alarm_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         rd_begin,
  input  logic         rd_end,
  input  logic [N-1:0] hit,
  output logic [N-1:0] flags
);
  logic in_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_read <= 1'b0;
    else if (wipe)     in_read <= 1'b0;
    else if (rd_begin) in_read <= 1'b1;
    else if (rd_end)   in_read <= 1'b0;
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic snap;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
        snap     <= 1'b0;
      end else if (wipe) begin
        flags[i] <= 1'b0;
        snap     <= 1'b0;
      end else begin
        if (rd_begin) snap <= flags[i];
        else if (rd_end) snap <= 1'b0;
        if (rd_end && in_read) flags[i] <= (flags[i] & ~snap) | hit[i];
        else                   flags[i] <= flags[i] | hit[i];
      end
    end
  end
endmodule

// File: rtl/rtc_status_guard.sv
module rtc_status_guard
  import rtc_sr_pkg::*;
#(
  parameter int            AW      = ADDR_W,
  parameter logic [AW-1:0] SR_ADDR = 6'h3F,
  parameter logic [AW-1:0] WIN_LO  = 6'h10,
  parameter logic [AW-1:0] WIN_HI  = 6'h37,
  parameter logic [AW-1:0] CLK_LO  = 6'h30,
  parameter logic [AW-1:0] CLK_HI  = 6'h37
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_lost,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_stb,
  input  logic [7:0]    wr_data,
  input  logic          rd_stb,
  input  logic          byte_done,
  input  logic          stop,
  input  logic          on_batt,
  input  logic          osc_bad,
  input  logic [1:0]    alarm_hit,
  output logic [7:0]    rd_data,
  output logic [AW-1:0] ptr_addr,
  output logic          wr_ack,
  output logic          ccr_wr_en,
  output logic [AW-1:0] ccr_wr_addr,
  output logic [7:0]    ccr_wr_data,
  output logic          ccr_wr_permit
);
  localparam int NUM_ALM = 2;

  logic [AW-1:0]      ptr;
  logic               arm, key, loss;
  logic [NUM_ALM-1:0] al_flags;
  logic               sel_sr, in_win, in_clk;
  logic               wr_go, clk_wr_go;
  logic [7:0]         sr_word;

  rtc_sr_addr_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(addr_ld), .load_val(addr_in),
    .advance(byte_done), .ptr(ptr)
  );

  assign sel_sr    = (ptr == SR_ADDR);
  assign in_win    = (ptr >= WIN_LO) && (ptr <= WIN_HI);
  assign in_clk    = (ptr >= CLK_LO) && (ptr <= CLK_HI);
  assign wr_go     = wr_stb && in_win && ccr_wr_permit;
  assign clk_wr_go = wr_go && in_clk;

  rtc_sr_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .wipe(pwr_lost), .sr_wr(wr_stb && sel_sr),
    .wr_byte(wr_data), .stop(stop), .arm(arm), .key(key)
  );

  rtc_sr_alarm_flags #(.N(NUM_ALM)) u_alm (
    .clk(clk), .rst_n(rst_n), .wipe(pwr_lost), .rd_begin(rd_stb && sel_sr),
    .rd_end(byte_done), .hit(alarm_hit), .flags(al_flags)
  );

  assign ccr_wr_permit = arm && key;
  assign ptr_addr      = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         loss <= 1'b1;
    else if (pwr_lost)  loss <= 1'b1;
    else if (clk_wr_go) loss <= 1'b0;
  end

  always_comb begin
    sr_word           = '0;
    sr_word[BIT_BATT] = on_batt;
    sr_word[BIT_ALM1] = al_flags[1];
    sr_word[BIT_ALM0] = al_flags[0];
    sr_word[BIT_OSC]  = osc_bad;
    sr_word[BIT_KEY]  = key;
    sr_word[BIT_ARM]  = arm;
    sr_word[BIT_LOSS] = loss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= sel_sr ? sr_word : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ack      <= 1'b0;
      ccr_wr_en   <= 1'b0;
      ccr_wr_addr <= '0;
      ccr_wr_data <= '0;
    end else begin
      wr_ack    <= wr_stb;
      ccr_wr_en <= wr_go;
      if (wr_go) begin
        ccr_wr_addr <= ptr;
        ccr_wr_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rtc_status_guard_chk.sv
module rtc_status_guard_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_lost,
  input logic          addr_ld,
  input logic          wr_stb,
  input logic          stop,
  input logic          byte_done,
  input logic [1:0]    alarm_hit,
  input logic [7:0]    rd_data,
  input logic [AW-1:0] ptr_addr,
  input logic          wr_ack,
  input logic          ccr_wr_en,
  input logic          ccr_wr_permit,
  input logic [1:0]    al_flags,
  input logic          loss
);
  localparam logic [AW-1:0] ONE = AW'(1);

  AST_RSV_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] == 1'b0); // R2

  AST_PERMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccr_wr_permit) |-> $past(stop)); // R4

  AST_CCR_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_wr_en |-> $past(ccr_wr_permit) && $past(wr_stb)); // R5

  AST_ACK_EVERY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> wr_ack); // R5

  AST_ALARM_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit[0] && !pwr_lost |=> al_flags[0]); // R6

  AST_ALARM_CATCH1: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit[1] && !pwr_lost |=> al_flags[1]); // R6

  AST_LOSS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_lost |=> loss); // R8

  AST_LOSS_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loss) |-> ccr_wr_en); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !addr_ld |=> ptr_addr == $past(ptr_addr) + ONE); // R9

  AST_WIPE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_lost |=> !ccr_wr_permit && al_flags == 2'b00); // R10
endmodule

bind rtc_status_guard rtc_status_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost), .addr_ld(addr_ld),
  .wr_stb(wr_stb), .stop(stop), .byte_done(byte_done), .alarm_hit(alarm_hit),
  .rd_data(rd_data), .ptr_addr(ptr_addr), .wr_ack(wr_ack),
  .ccr_wr_en(ccr_wr_en), .ccr_wr_permit(ccr_wr_permit),
  .al_flags(al_flags), .loss(loss)
);

// File: tb/sim_rtc_status_guard.sv
`timescale 1ns/1ps
module sim_rtc_status_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_lost = 1'b0, addr_ld = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic       byte_done = 1'b0, stop = 1'b0, on_batt = 1'b0, osc_bad = 1'b0;
  logic [5:0] addr_in = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] alarm_hit = '0;
  logic [7:0] rd_data, ccr_wr_data;
  logic [5:0] ptr_addr, ccr_wr_addr;
  logic       wr_ack, ccr_wr_en, ccr_wr_permit;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_status_guard u0 (
    .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost), .addr_ld(addr_ld),
    .addr_in(addr_in), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .byte_done(byte_done), .stop(stop), .on_batt(on_batt), .osc_bad(osc_bad),
    .alarm_hit(alarm_hit), .rd_data(rd_data), .ptr_addr(ptr_addr),
    .wr_ack(wr_ack), .ccr_wr_en(ccr_wr_en), .ccr_wr_addr(ccr_wr_addr),
    .ccr_wr_data(ccr_wr_data), .ccr_wr_permit(ccr_wr_permit)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_addr(input logic [5:0] a);
    @(negedge clk); addr_ld = 1'b1; addr_in = a;
    @(negedge clk); addr_ld = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack, output logic en);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0; ack = wr_ack; en = ccr_wr_en;
  endtask

  task automatic rd_byte(output logic [7:0] d);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; d = rd_data;
  endtask

  task automatic end_byte();
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0;
  endtask

  task automatic end_txn();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] d);
    logic a, e;
    set_addr(6'h3F); wr_byte(d, a, e); end_byte(); end_txn();
  endtask

  task automatic sr_read(output logic [7:0] d);
    set_addr(6'h3F); rd_byte(d); end_byte(); end_txn();
  endtask

  task automatic hit_alarm(input int i);
    @(negedge clk); alarm_hit[i] = 1'b1;
    @(negedge clk); alarm_hit = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 permit after reset", ccr_wr_permit, 0);
    sr_read(d);
    chk("R1 status after reset", d, 8'h01);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    on_batt = 1'b1; osc_bad = 1'b1;
    sr_read(d);
    chk("R2 batt/osc bits, bit3 zero", d, 8'h91);
    chk("R9 pointer wraps after 0x3F", ptr_addr, 6'h00);
    on_batt = 1'b0; osc_bad = 1'b0;
  endtask

  task automatic t_arm();
    logic [7:0] d;
    logic a, e;
    sr_write(8'h04); sr_read(d);
    chk("R3 odd pattern ignored", d, 8'h01);
    set_addr(6'h3F); wr_byte(8'h02, a, e); end_byte();
    rd_byte(d);
    chk("R3 no effect before stop (read 0x3F+1=0x00)", d, 8'h00);
    end_txn(); sr_read(d);
    chk("R3 0x02 sets ARM", d, 8'h03);
    sr_write(8'h03); sr_read(d);
    chk("R3 0x03 leaves ARM", d, 8'h03);
    sr_write(8'h00); sr_read(d);
    chk("R3 0x00 clears ARM", d, 8'h01);
  endtask

  task automatic t_key();
    logic [7:0] d;
    sr_write(8'h06); sr_read(d);
    chk("R4 0x06 with ARM low ignored", d, 8'h01);
    chk("R4 permit low", ccr_wr_permit, 0);
    sr_write(8'h02); sr_write(8'h06); sr_read(d);
    chk("R4 ordered unlock", d, 8'h07);
    chk("R4 permit high", ccr_wr_permit, 1);
    sr_write(8'h00);
  endtask

  task automatic t_blocked();
    logic [7:0] d;
    logic a, e;
    set_addr(6'h31); wr_byte(8'h5A, a, e); end_byte(); end_txn();
    chk("R5 blocked write acked", a, 1);
    chk("R5 blocked write dropped", e, 0);
    sr_read(d);
    chk("R8 blocked write keeps LOSS", d, 8'h01);
  endtask

  task automatic t_loss();
    logic [7:0] d;
    logic a, e;
    sr_write(8'h02); sr_write(8'h06);
    set_addr(6'h20); wr_byte(8'hA5, a, e);
    chk("R5 permitted write passes", e, 1);
    chk("R5 write address", ccr_wr_addr, 6'h20);
    chk("R5 write data", ccr_wr_data, 8'hA5);
    end_byte(); end_txn(); sr_read(d);
    chk("R8 control write keeps LOSS", d, 8'h07);
    set_addr(6'h31); wr_byte(8'h12, a, e); end_byte(); end_txn(); sr_read(d);
    chk("R8 clock write clears LOSS", d, 8'h06);
    @(negedge clk); pwr_lost = 1'b1;
    @(negedge clk); pwr_lost = 1'b0;
    chk("R10 permit dropped", ccr_wr_permit, 0);
    sr_read(d);
    chk("R8 R10 power loss restores 0x01", d, 8'h01);
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    hit_alarm(0); repeat (3) @(negedge clk);
    sr_read(d);
    chk("R6 ALM0 sticky and shown", d, 8'h21);
    sr_read(d);
    chk("R7 ALM0 cleared by read", d, 8'h01);
    hit_alarm(0);
    set_addr(6'h3F); rd_byte(d);
    chk("R7 read shows ALM0 only", d, 8'h21);
    hit_alarm(1); end_byte(); end_txn();
    sr_read(d);
    chk("R7 ALM1 set mid-read survives", d, 8'h41);
    sr_read(d);
    chk("R7 ALM1 cleared next read", d, 8'h01);
  endtask

  task automatic t_ptr();
    logic [7:0] d;
    set_addr(6'h3E); rd_byte(d);
    chk("R9 non-status address reads 0", d, 8'h00);
    end_byte();
    chk("R9 pointer advanced", ptr_addr, 6'h3F);
    rd_byte(d);
    chk("R9 current-address read hits status", d, 8'h01);
    end_byte(); end_txn();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset(); t_layout(); t_arm(); t_key(); t_blocked();
    t_loss(); t_alarm(); t_ptr();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule